// File: doc/BRIEF.md
# Nonvolatile Byte Write Sequencer

This block controls programming of a small on-chip nonvolatile byte array through four byte-wide registers: a control register, an address register, a data register and a read window onto the array cell selected by the address register. A programming cycle runs only after software has armed it. Software first sets a self-clearing arming bit. It must then set the program strobe while that bit is still set. A two-bit operation field selects erase, write or combined erase-and-write, and each operation has its own length in clock cycles.

The strobe reads back as a busy flag for the whole operation, and hardware clears it when the cycle count runs out. When the operation starts, the address, data and operation are captured, so software may change the registers while the operation is in progress. A level-type ready interrupt is raised while the block is idle, its enable bit is set and the global interrupt enable is high. A separate flash-busy input blocks starts. There are two resets. The system reset does not abort an operation in progress, and it keeps the operation field while the block is busy. The power-on reset clears everything.

Top module: `nvm_write_seq`

## Requirements
- R1: After power-on reset the control register reads 0x00 and readyIrq is low.
- R2: A control write with bit1 (arm) = 1 and bit0 (strobe) = 0 sets the arm bit, which reads back at bit1. Hardware clears it on the fourth clock edge after the arming edge. A strobe written on any of those four edges is accepted, and a strobe written on the fifth edge or later is ignored.
- R3: Writing bit0 = 1 while the arm bit is clear starts no operation: bit0 reads back 0.
- R4: While busy, writes to the operation field (control bits 5:4) are ignored.
- R5: A strobe that arrives while flashBusy is high starts nothing and clears the arm bit.
- R6: Operation 00 keeps busy for T_BOTH cycles. Operations 01, 10 and 11 keep busy for T_ONE cycles.
- R7: Field encoding at completion: 00 stores the data byte; 01 sets the cell to 0xFF; 10 ANDs the data into the cell; 11 leaves the cell unchanged.
- R8: readyIrq equals (not busy) AND (control bit2) AND globalIntEn, and it is a level.
- R9: A system reset (rstN low) clears the arm bit, bit2 and the address and data registers. It clears the operation field only when idle. An operation in progress continues and completes.
- R10: The address and data are captured at the start edge. Register writes made while busy do not change the cell that is programmed or the value written to it.
- R11: Busy (bit0) reads 1 from the edge after the strobe onward, and hardware clears it when the operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low, clears all state |
| rstN | input | 1 | Synchronous system reset, active low, spares an operation in progress |
| regWe | input | 1 | Register write enable |
| regSel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 array cell (read only) |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data of the selected register |
| flashBusy | input | 1 | High while flash self-programming is running, blocks starts |
| globalIntEn | input | 1 | Global interrupt enable |
| readyIrq | output | 1 | Level ready interrupt |

## Verification
The hardest case to produce is a strobe that lands exactly on the last edge of the arming window, and then one that lands a single edge later. The bench drives register writes at falling edges, counts the idle cycles between the arming write and the strobe write, and runs both cases. A second hard case is a system reset in the middle of an operation. The bench starts an erase, pulses rstN while the block is busy, and then checks that busy and the operation field survived and that the cell was still erased.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_CELL = 2'd3;

  typedef enum logic [1:0] {
    OP_BOTH  = 2'b00,
    OP_ERASE = 2'b01,
    OP_WRITE = 2'b10,
    OP_NONE  = 2'b11
  } nvmOp_e;

  typedef struct packed {
    logic   capture;
    logic   commit;
    nvmOp_e opMode;
  } nvmStrobe_t;
endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ARM_WINDOW = 4,
  parameter int T_BOTH     = 40,
  parameter int T_ONE      = 20
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regSel,
  input  logic [5:0] ctlBits,
  input  logic       flashBusy,
  output logic       busy,
  output logic       armed,
  output logic       irqEn,
  output nvmOp_e     modeQ,
  output nvmStrobe_t strobes
);
  localparam int TW = $clog2(T_BOTH + 1);
  localparam int AW = $clog2(ARM_WINDOW + 1);

  logic [TW-1:0] timer;
  logic [AW-1:0] armCnt;
  nvmOp_e        opMode;
  nvmOp_e        newMode;
  logic          ctlWr, goReq, startOk;

  function automatic logic [TW-1:0] opLen(input nvmOp_e m);
    return (m == OP_BOTH) ? TW'(T_BOTH - 1) : TW'(T_ONE - 1);
  endfunction

  assign newMode = nvmOp_e'(ctlBits[5:4]);
  assign ctlWr   = regWe && (regSel == SEL_CTRL) && rstN;
  assign goReq   = ctlWr && ctlBits[0];
  assign startOk = goReq && armed && !busy && !flashBusy;

  // operation timer, untouched by the system reset
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      busy   <= 1'b0;
      timer  <= '0;
      opMode <= OP_BOTH;
    end else if (busy) begin
      if (timer == '0) busy <= 1'b0;
      else             timer <= timer - 1'b1;
    end else if (startOk) begin
      busy   <= 1'b1;
      timer  <= opLen(newMode);
      opMode <= newMode;
    end
  end

  // control fields and arming window
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      armed  <= 1'b0;
      armCnt <= '0;
      irqEn  <= 1'b0;
      modeQ  <= OP_BOTH;
    end else if (!rstN) begin
      armed <= 1'b0;
      irqEn <= 1'b0;
      if (!busy) modeQ <= OP_BOTH;
    end else begin
      if (ctlWr) begin
        irqEn <= ctlBits[2];
        if (!busy) modeQ <= newMode;
      end
      if (armed) begin
        if (goReq || armCnt == '0) armed <= 1'b0;
        else                       armCnt <= armCnt - 1'b1;
      end else if (ctlWr && ctlBits[1] && !ctlBits[0]) begin
        armed  <= 1'b1;
        armCnt <= AW'(ARM_WINDOW - 1);
      end
    end
  end

  assign strobes.capture = startOk;
  assign strobes.commit  = busy && (timer == '0);
  assign strobes.opMode  = opMode;
endmodule

// File: rtl/nvm_dpath.sv
module nvm_dpath
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  nvmStrobe_t        strobes,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [DATA_W-1:0] cellQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (regWe) begin
      if (regSel == SEL_ADDR) addrQ <= regWdata[ADDR_W-1:0];
      if (regSel == SEL_DATA) dataQ <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      opAddr <= '0;
      opData <= '0;
    end else if (strobes.capture) begin
      opAddr <= addrQ;
      opData <= dataQ;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) begin
      unique case (strobes.opMode)
        OP_BOTH:  store[opAddr] <= opData;
        OP_ERASE: store[opAddr] <= '1;
        OP_WRITE: store[opAddr] <= store[opAddr] & opData;
        default:  ;
      endcase
    end
  end

  assign cellQ = store[addrQ];
endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
  import nvm_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int ARM_WINDOW = 4,
  parameter int T_BOTH     = 40,
  parameter int T_ONE      = 20
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              flashBusy,
  input  logic              globalIntEn,
  output logic              readyIrq
);
  logic              busy, armed, irqEn;
  nvmOp_e            modeQ;
  nvmStrobe_t        strobes;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, cellQ;

  nvm_ctrl #(.ARM_WINDOW(ARM_WINDOW), .T_BOTH(T_BOTH), .T_ONE(T_ONE)) u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .ctlBits(regWdata[5:0]), .flashBusy(flashBusy), .busy(busy),
    .armed(armed), .irqEn(irqEn), .modeQ(modeQ), .strobes(strobes)
  );

  nvm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .porN(porN), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .strobes(strobes), .addrQ(addrQ), .dataQ(dataQ),
    .cellQ(cellQ)
  );

  always_comb begin
    unique case (regSel)
      SEL_CTRL: regRdata = DATA_W'({modeQ, 1'b0, irqEn, armed, busy});
      SEL_ADDR: regRdata = DATA_W'(addrQ);
      SEL_DATA: regRdata = dataQ;
      default:  regRdata = cellQ;
    endcase
  end

  assign readyIrq = !busy && irqEn && globalIntEn;
endmodule

// File: rtl/nvm_write_seq_chk.sv
module nvm_write_seq_chk
  import nvm_pkg::*;
#(
  parameter int ARM_WINDOW = 4,
  parameter int T_BOTH     = 40,
  parameter int T_ONE      = 20
) (
  input logic   clk,
  input logic   porN,
  input logic   rstN,
  input logic   busy,
  input logic   armed,
  input nvmOp_e modeQ,
  input nvmOp_e opMode,
  input logic   flashBusy,
  input logic   readyIrq
);
  int armAge;
  int busyLen;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      armAge  <= 0;
      busyLen <= 0;
    end else begin
      armAge  <= armed ? armAge + 1 : 0;
      busyLen <= busy ? busyLen + 1 : 0;
    end
  end

  a_r2_arm_window: assert property (@(posedge clk) disable iff (!porN)
    armed |-> armAge < ARM_WINDOW);
  a_r3_start_needs_arm: assert property (@(posedge clk) disable iff (!porN)
    $rose(busy) |-> $past(armed));
  a_r5_flash_blocks: assert property (@(posedge clk) disable iff (!porN)
    $rose(busy) |-> !$past(flashBusy));
  a_r4_mode_frozen: assert property (@(posedge clk) disable iff (!porN)
    (busy && $past(busy)) |-> $stable(modeQ));
  a_r6_duration: assert property (@(posedge clk) disable iff (!porN)
    $fell(busy) |-> busyLen == ((opMode == OP_BOTH) ? T_BOTH : T_ONE));
  a_r8_irq_quiet_busy: assert property (@(posedge clk) disable iff (!porN)
    busy |-> !readyIrq);
  a_r9_reset_keeps_mode: assert property (@(posedge clk) disable iff (!porN)
    (!rstN && busy) |=> $stable(modeQ));
endmodule

bind nvm_write_seq nvm_write_seq_chk #(
  .ARM_WINDOW(ARM_WINDOW), .T_BOTH(T_BOTH), .T_ONE(T_ONE)
) u_chk (
  .clk(clk), .porN(porN), .rstN(rstN), .busy(busy), .armed(armed),
  .modeQ(modeQ), .opMode(strobes.opMode), .flashBusy(flashBusy),
  .readyIrq(readyIrq)
);

// File: tb/sim_nvm_write_seq.sv
`timescale 1ns/1ps
module sim_nvm_write_seq;
  localparam int T_BOTH = 40;
  localparam int T_ONE  = 20;

  logic       clk = 1'b0;
  logic       porN = 1'b0, rstN = 1'b1;
  logic       regWe = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       flashBusy = 1'b0, globalIntEn = 1'b0;
  logic       readyIrq;

  always #5 clk = ~clk;

  nvm_write_seq #(.ADDR_W(6), .DATA_W(8), .ARM_WINDOW(4), .T_BOTH(T_BOTH), .T_ONE(T_ONE)) u0 (
    .clk(clk), .porN(porN), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .flashBusy(flashBusy),
    .globalIntEn(globalIntEn), .readyIrq(readyIrq)
  );

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t queueExp[$];
  event  sampleEv;
  int    nChecks = 0, nFail = 0;
  bit    finished = 1'b0;

  // monitor: pops the expected item and compares it with the port
  initial begin
    forever begin
      @(sampleEv);
      while (queueExp.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = queueExp.pop_front();
        act = (it.sel == 4) ? {7'd0, readyIrq} : regRdata;
        nChecks++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // sel 0..3 reads a register, 4 samples readyIrq
  task automatic check(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    if (sel < 4) regSel = 2'(sel);
    it.sel = sel; it.exp = exp; it.tag = tag;
    queueExp.push_back(it);
    #2;
    ->sampleEv;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // arm, strobe and time a full operation with irqEn kept set
  task automatic runOp(input logic [1:0] op, input int len);
    logic [7:0] m;
    m = {2'b00, op, 4'b0000};
    wr(2'd0, m | 8'h06);
    wr(2'd0, m | 8'h05);
    check(0, m | 8'h05, "R11 busy set, arm consumed");
    check(4, 8'h00, "R8 irq low while busy");
    idle(len - 1);
    check(0, m | 8'h05, "R6 still busy on last cycle");
    idle(1);
    check(0, m | 8'h04, "R6 R11 busy cleared at length");
    check(4, 8'h01, "R8 irq back when idle");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    idle(2);
    porN = 1'b1;
    idle(1);
    check(0, 8'h00, "R1 control after power-on");
    check(4, 8'h00, "R1 irq after power-on");

    wr(2'd0, 8'h04);
    globalIntEn = 1'b1;
    check(4, 8'h01, "R8 irq with enables");
    globalIntEn = 1'b0;
    check(4, 8'h00, "R8 irq gated by global enable");
    globalIntEn = 1'b1;

    wr(2'd1, 8'd5); wr(2'd2, 8'h3C);
    wr(2'd0, 8'h05);
    check(0, 8'h04, "R3 strobe without arm ignored");

    runOp(2'b00, T_BOTH);
    check(3, 8'h3C, "R7 erase-and-write stores data");
    runOp(2'b01, T_ONE);
    check(3, 8'hFF, "R7 erase gives 0xFF");
    wr(2'd2, 8'hA5);
    runOp(2'b10, T_ONE);
    check(3, 8'hA5, "R7 write-only into erased");
    wr(2'd2, 8'h0F);
    runOp(2'b10, T_ONE);
    check(3, 8'h05, "R7 write-only ANDs");
    wr(2'd2, 8'h00);
    runOp(2'b11, T_ONE);
    check(3, 8'h05, "R7 reserved op leaves cell");

    // R4 and R10: change mode, address and data while busy
    wr(2'd1, 8'd8);
    runOp(2'b01, T_ONE);
    wr(2'd1, 8'd7); wr(2'd2, 8'h11);
    wr(2'd0, 8'h06); wr(2'd0, 8'h05);
    wr(2'd0, 8'h14);
    check(0, 8'h05, "R4 mode write ignored while busy");
    wr(2'd1, 8'd8); wr(2'd2, 8'h99);
    idle(T_BOTH + 2);
    check(3, 8'hFF, "R10 later address untouched");
    wr(2'd1, 8'd7);
    check(3, 8'h11, "R10 captured address and data used");

    // R2 window
    wr(2'd0, 8'h06);
    check(0, 8'h06, "R2 arm bit set");
    idle(3);
    check(0, 8'h06, "R2 arm held on fourth cycle");
    idle(1);
    check(0, 8'h04, "R2 arm self-cleared");
    wr(2'd0, 8'h06); idle(2); wr(2'd0, 8'h05);
    check(0, 8'h05, "R2 strobe on last window edge accepted");
    idle(T_BOTH + 2);
    wr(2'd0, 8'h06); idle(3); wr(2'd0, 8'h05);
    check(0, 8'h04, "R2 strobe after window ignored");

    // R5 flash busy
    flashBusy = 1'b1;
    wr(2'd0, 8'h06); wr(2'd0, 8'h05);
    check(0, 8'h04, "R5 flash busy blocks start and clears arm");
    flashBusy = 1'b0;

    // R9 system reset mid-operation
    wr(2'd1, 8'd9); wr(2'd2, 8'h00);
    wr(2'd0, 8'h16); wr(2'd0, 8'h15);
    idle(3);
    rstN = 1'b0;
    idle(1);
    rstN = 1'b1;
    check(0, 8'h11, "R9 reset spares busy and mode");
    idle(T_ONE + 2);
    wr(2'd1, 8'd9);
    check(3, 8'hFF, "R9 operation completed through reset");
    wr(2'd0, 8'h24);
    rstN = 1'b0;
    idle(1);
    rstN = 1'b1;
    check(0, 8'h00, "R9 idle reset clears mode");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule